// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits between a set of DMA channels and the host bus. Each channel can ask for service in two ways: by raising its request line, which may change at any time with no relation to the block's clock, or by having software set that channel's bit in an internal request register. Hardware lines pass through a two-stage synchronizer and are then gated by the channel mask. Software bits bypass the mask. The combined set of pending requests drives one bus request toward the host.

When the host answers with a grant, a fixed-priority picker chooses the lowest-numbered channel that is still pending. The block captures that index, raises the acknowledge line for that channel, and signals the transfer sequencer that a serviced channel is ready. The index stays frozen until the sequencer reports completion. A software request bit clears itself when its own channel finishes service.

A hardware request that falls before its acknowledge rises is dropped. If no request is left by the time the grant arrives, the bus request is withdrawn and no channel is acknowledged.

Top module: `dma_req_front`

## Requirements
- R1: While reset is high and on the first clock after it, bus_req, pend and every ack bit are 0 and chan_sel is 0.
- R2: A hardware request line passes through two synchronizing flops. A rise of req_async[i] driven before clock edge 1 raises bus_req after edge 3 and not after edge 2.
- R3: A hardware request on a channel whose mask bit is 1 is ignored: bus_req stays 0 and no ack bit rises, even when bus_grant is driven high.
- R4: Any unmasked synchronized hardware request, or any set software request bit, raises bus_req. bus_req stays high for the whole time pend is high.
- R5: A one-cycle pulse on sw_req_set[i] sets software request bit i whatever mask[i] is. bus_req rises after the second clock edge that follows the pulse.
- R6: When several channels are pending, the lowest channel number wins, whether the requests come from hardware or software.
- R7: A bus_grant seen while a request is pending moves the block to service on the next edge. Then pend is 1, chan_sel holds the winner, and ack has exactly one bit set, at position chan_sel. chan_sel and ack stay unchanged until svc_done, even if other requests appear or vanish.
- R8: If every pending request disappears before bus_grant, bus_req falls, and a later bus_grant produces no ack and no pend.
- R9: svc_done while pend is 1 clears pend and ack on the next edge and clears the software request bit of the served channel. With nothing else pending, bus_req then stays 0.
- R10: The winner is picked from the requests still pending in the cycle of the grant, not from those that were present when bus_req first rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_async | input | NCH | Per-channel hardware request lines, asynchronous |
| mask | input | NCH | Per-channel mask; 1 blocks that channel's hardware request |
| sw_req_set | input | NCH | Pulse to set a channel's software request bit |
| bus_grant | input | 1 | Host grant answering bus_req |
| svc_done | input | 1 | Sequencer reports the current service has finished |
| bus_req | output | 1 | Bus request toward the host |
| pend | output | 1 | A channel is granted and ready for the sequencer |
| chan_sel | output | CW | Index of the granted channel |
| ack | output | NCH | One-hot acknowledge to the granted channel |

## Verification
The hardest situation to reach is the one where the set of pending channels changes between the moment bus_req rises and the moment the grant arrives. This covers the discard of a request that fell too early and the choice among the survivors. The bench reaches it by raising two channels and waiting for bus_req. It then drops the higher-priority line and lets it clear the synchronizer before granting, and separately drops every line before granting. A software bit that outlives the service of another channel is reached by posting one together with a higher-priority hardware request, so that the software bit must raise bus_req again after the first service ends.

// File: rtl/dmafe_pkg.sv
`timescale 1ns/1ps
package dmafe_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_HOLD  = 2'd1,
        ARB_SERVE = 2'd2
    } arb_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dmafe_sync.sv
`timescale 1ns/1ps
module dmafe_sync #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] async_in,
    output logic [NCH-1:0] sync_out
);
    logic [NCH-1:0] stage1;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[g]   <= 1'b0;
                sync_out[g] <= 1'b0;
            end else begin
                stage1[g]   <= async_in[g];
                sync_out[g] <= stage1[g];
            end
        end
    end
endmodule

// File: rtl/dmafe_swreq.sv
`timescale 1ns/1ps
module dmafe_swreq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    output logic [NCH-1:0] sw_q
);
    always_ff @(posedge clk) begin
        if (rst) sw_q <= '0;
        else     sw_q <= (sw_q | set_vec) & ~clr_vec;
    end

    // R9: a bit named by the clear vector and not set again is gone next cycle
    a_r9_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0 && (clr_vec & set_vec) == '0) |=> ((sw_q & $past(clr_vec)) == '0));
endmodule

// File: rtl/dmafe_arb.sv
`timescale 1ns/1ps
module dmafe_arb
    import dmafe_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] eff,
    input  logic           bus_grant,
    input  logic           svc_done,
    output logic           bus_req,
    output logic           pend,
    output logic [CW-1:0]  chan_sel,
    output logic [NCH-1:0] ack,
    output logic [NCH-1:0] clr_vec
);
    arb_state_t     state;
    logic [CW-1:0]  chan_q;
    logic [CW-1:0]  win;
    logic           any;

    // fixed priority: lowest index wins
    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eff[i]) win = CW'(i);
        end
    end

    assign any = |eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ARB_IDLE;
            chan_q <= '0;
        end else begin
            case (state)
                ARB_IDLE:  if (any) state <= ARB_HOLD;
                ARB_HOLD: begin
                    if (!any) begin
                        state <= ARB_IDLE;
                    end else if (bus_grant) begin
                        state  <= ARB_SERVE;
                        chan_q <= win;
                    end
                end
                ARB_SERVE: if (svc_done) state <= ARB_IDLE;
                default:   state <= ARB_IDLE;
            endcase
        end
    end

    assign bus_req  = (state != ARB_IDLE);
    assign pend     = (state == ARB_SERVE);
    assign chan_sel = chan_q;
    assign ack      = pend ? (NCH'(1) << chan_q) : '0;
    assign clr_vec  = (pend && svc_done) ? ack : '0;

    // R7: grant with a live request enters service on the next edge
    a_r7_grant_serves: assert property (@(posedge clk) disable iff (rst)
        (state == ARB_HOLD && any && bus_grant) |=> pend);

    // R7: selected channel frozen during service
    a_r7_chan_stable: assert property (@(posedge clk) disable iff (rst)
        (pend && !svc_done) |=> (pend && $stable(chan_sel)));

    // R9: completion releases the channel
    a_r9_done_release: assert property (@(posedge clk) disable iff (rst)
        (pend && svc_done) |=> (!pend && ack == '0));

    // R8: with nothing pending while waiting, the request is withdrawn
    a_r8_drop_withdraw: assert property (@(posedge clk) disable iff (rst)
        (state == ARB_HOLD && !any) |=> !bus_req);
endmodule

// File: rtl/dma_req_front.sv
`timescale 1ns/1ps
module dma_req_front
    import dmafe_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = idx_width(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_async,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] sw_req_set,
    input  logic           bus_grant,
    input  logic           svc_done,
    output logic           bus_req,
    output logic           pend,
    output logic [CW-1:0]  chan_sel,
    output logic [NCH-1:0] ack
);
    logic [NCH-1:0] hw_sync;
    logic [NCH-1:0] sw_q;
    logic [NCH-1:0] clr_vec;
    logic [NCH-1:0] eff;

    dmafe_sync #(.NCH(NCH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (req_async),
        .sync_out (hw_sync)
    );

    dmafe_swreq #(.NCH(NCH)) u_swreq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (sw_req_set),
        .clr_vec (clr_vec),
        .sw_q    (sw_q)
    );

    // masking applies to hardware lines only
    assign eff = (hw_sync & ~mask) | sw_q;

    dmafe_arb #(.NCH(NCH), .CW(CW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .eff       (eff),
        .bus_grant (bus_grant),
        .svc_done  (svc_done),
        .bus_req   (bus_req),
        .pend      (pend),
        .chan_sel  (chan_sel),
        .ack       (ack),
        .clr_vec   (clr_vec)
    );

    // R4: bus held while a channel is in service
    a_r4_bus_held: assert property (@(posedge clk) disable iff (rst)
        pend |-> bus_req);

    // R7: exactly one acknowledge during service, none otherwise
    a_r7_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        pend ? ($countones(ack) == 1) : (ack == '0));
endmodule

// File: tb/test_dma_req_front.sv
`timescale 1ns/1ps
module test_dma_req_front;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] req_async = '0;
    logic [NCH-1:0] mask = '0;
    logic [NCH-1:0] sw_req_set = '0;
    logic           bus_grant = 1'b0;
    logic           svc_done = 1'b0;
    logic           bus_req;
    logic           pend;
    logic [1:0]     chan_sel;
    logic [NCH-1:0] ack;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_req_front #(.NCH(NCH)) i_dma_req_front (
        .clk(clk), .rst(rst), .req_async(req_async), .mask(mask),
        .sw_req_set(sw_req_set), .bus_grant(bus_grant), .svc_done(svc_done),
        .bus_req(bus_req), .pend(pend), .chan_sel(chan_sel), .ack(ack)
    );

    // vector: {req[3:0], mask[3:0], expect_any, 1'b0, expect_chan[1:0]}
    localparam logic [11:0] VEC [8] = '{
        {4'b0001, 4'b0000, 1'b1, 1'b0, 2'd0},
        {4'b1010, 4'b0000, 1'b1, 1'b0, 2'd1},
        {4'b1100, 4'b0000, 1'b1, 1'b0, 2'd2},
        {4'b1000, 4'b0000, 1'b1, 1'b0, 2'd3},
        {4'b0011, 4'b0001, 1'b1, 1'b0, 2'd1},
        {4'b0101, 4'b0101, 1'b0, 1'b0, 2'd0},
        {4'b1111, 4'b0111, 1'b1, 1'b0, 2'd3},
        {4'b1110, 4'b1000, 1'b1, 1'b0, 2'd1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_service();
        bus_grant = 1'b0;
        req_async = '0;
        tick(2);
        svc_done = 1'b1;
        tick(1);
        svc_done = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        tick(3);
        chk("R1 bus_req in reset", 32'(bus_req), 0);
        chk("R1 ack in reset", 32'(ack), 0);
        rst = 1'b0;
        tick(1);
        chk("R1 pend after reset", 32'(pend), 0);
        chk("R1 chan_sel after reset", 32'(chan_sel), 0);

        // table walk: R3 R4 R6 R7 R9
        for (int k = 0; k < 8; k++) begin
            logic [3:0] vr;
            logic [3:0] vm;
            logic       vany;
            logic [1:0] vch;
            {vr, vm, vany} = VEC[k][11:3];
            vch = VEC[k][1:0];
            req_async = vr;
            mask = vm;
            tick(3);
            chk($sformatf("R4/R3 bus_req vec%0d", k), 32'(bus_req), 32'(vany));
            bus_grant = 1'b1;
            tick(1);
            if (vany) begin
                chk($sformatf("R6 chan_sel vec%0d", k), 32'(chan_sel), 32'(vch));
                chk($sformatf("R7 ack vec%0d", k), 32'(ack), 32'(4'b0001 << vch));
                chk($sformatf("R7 pend vec%0d", k), 32'(pend), 1);
                bus_grant = 1'b0;
                req_async = '0;
                tick(2);
                chk($sformatf("R7 chan held vec%0d", k), 32'(chan_sel), 32'(vch));
                svc_done = 1'b1;
                tick(1);
                svc_done = 1'b0;
                chk($sformatf("R9 pend cleared vec%0d", k), 32'(pend), 0);
                chk($sformatf("R9 ack cleared vec%0d", k), 32'(ack), 0);
                tick(1);
                chk($sformatf("R9 bus idle vec%0d", k), 32'(bus_req), 0);
            end else begin
                chk($sformatf("R3 no ack masked vec%0d", k), 32'(ack), 0);
                bus_grant = 1'b0;
                req_async = '0;
            end
            mask = '0;
            tick(3);
        end

        // R2 synchronizer latency, then R8 early drop
        req_async = 4'b0100;
        tick(2);
        chk("R2 not after two edges", 32'(bus_req), 0);
        tick(1);
        chk("R2 after three edges", 32'(bus_req), 1);
        req_async = '0;
        tick(3);
        chk("R8 bus_req withdrawn", 32'(bus_req), 0);
        bus_grant = 1'b1;
        tick(2);
        chk("R8 no ack after late grant", 32'(ack), 0);
        chk("R8 no pend after late grant", 32'(pend), 0);
        bus_grant = 1'b0;
        tick(1);

        // R5 software request bypasses mask
        mask = 4'b1111;
        sw_req_set = 4'b0100;
        tick(1);
        sw_req_set = '0;
        chk("R5 not after one edge", 32'(bus_req), 0);
        tick(1);
        chk("R5 bus_req from software", 32'(bus_req), 1);
        bus_grant = 1'b1;
        tick(1);
        chk("R5 software channel served", 32'(chan_sel), 2);
        chk("R5 software ack", 32'(ack), 32'(4'b0100));
        finish_service();
        tick(2);
        chk("R9 software bit self-cleared", 32'(bus_req), 0);
        mask = '0;

        // R10 winner from requests alive at grant, R7 hold under new request
        req_async = 4'b0101;
        tick(3);
        chk("R10 bus_req raised", 32'(bus_req), 1);
        req_async = 4'b0100;
        tick(2);
        bus_grant = 1'b1;
        tick(1);
        chk("R10 survivor wins", 32'(chan_sel), 2);
        req_async = 4'b0101;
        tick(3);
        chk("R7 chan stable under higher request", 32'(chan_sel), 2);
        chk("R7 ack stable under higher request", 32'(ack), 32'(4'b0100));
        finish_service();
        tick(3);

        // R6 mixed sources: hardware ch1 beats software ch3; software bit survives
        req_async = 4'b0010;
        sw_req_set = 4'b1000;
        tick(1);
        sw_req_set = '0;
        tick(2);
        bus_grant = 1'b1;
        tick(1);
        chk("R6 hardware ch1 over software ch3", 32'(chan_sel), 1);
        finish_service();
        chk("R9 pend cleared mixed", 32'(pend), 0);
        tick(1);
        chk("R4 software bit re-raises bus_req", 32'(bus_req), 1);
        bus_grant = 1'b1;
        tick(1);
        chk("R6 software ch3 served next", 32'(chan_sel), 3);
        finish_service();
        tick(2);
        chk("R9 all clear at end", 32'(bus_req), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule